// File: doc/BRIEF.md
# Bus-Mapped 32x32 Multiplier

This peripheral sits on a 16-bit register bus and forms the 64-bit product of two 32-bit operands. Software writes each operand as two 16-bit halves, each to its own offset. The offset used for the low half of the first operand also fixes whether the product is signed or unsigned. Writing the upper half of the second operand starts the multiply. The product is then read back as four 16-bit words.

The first operand gets two loader offsets. Each of them clears the operand's upper half and records the signedness, so a 16-bit factor needs a single write. The second operand keeps its upper half until the triggering write, so both halves can be changed independently. The product sits in a register and is readable on the cycle after the trigger. Reads are combinational.

Top module: `mul32_periph`

## Requirements
- R1: After reset both operands and the product are zero and the mode is unsigned. A read of any of the four result offsets returns 0x0000.
- R2: A write to offset 0x00 loads bits 15:0 of operand A, clears bits 31:16 of operand A and selects unsigned mode.
- R3: A write to offset 0x04 loads bits 15:0 of operand A, clears bits 31:16 of operand A and selects signed mode.
- R4: A write to offset 0x02 or 0x06 replaces bits 31:16 of operand A, keeps bits 15:0 and leaves the mode unchanged.
- R5: A write to offset 0x10 loads bits 15:0 of operand B, keeps bits 31:16 of operand B and does not change the product.
- R6: A write to offset 0x12 loads bits 31:16 of operand B and starts the multiply. The new product is readable from the clock edge after the write and stays stable until the next trigger or reset.
- R7: In unsigned mode the product is A*B with both operands zero-extended to 64 bits.
- R8: In signed mode both operands are sign-extended from bit 31 before multiplying, and the result is the two's-complement 64-bit product.
- R9: Reads at offsets 0x14, 0x16, 0x18 and 0x1A return product bits 15:0, 31:16, 47:32 and 63:48 respectively.
- R10: Reads of any other offset return zero, and writes to any other offset change neither the operands, the mode nor the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data; zero when bus_rd is low |

## Verification
The checker watches the bus on every cycle. It checks that the product register changes only on the edge after a write to the trigger offset. It also checks that operand A's upper half is cleared by the loader writes and that the low half of operand B survives a write to its upper half. Unmapped and idle reads must return zero. The arithmetic itself, meaning the sign extension and the full 64-bit results in both modes, plus the readout of each word and the fact that stray writes change nothing, can only be shown by the bench's directed scenarios comparing read data against products computed independently.

// File: rtl/mul32_pkg.sv
package mul32_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned OPW    = 2 * BUS_W;
  localparam int unsigned PRODW  = 2 * OPW;
  localparam int unsigned NWORDS = PRODW / BUS_W;

  localparam logic [ADDR_W-1:0] OFS_A_LO_U = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_A_HI_U = 8'h02;
  localparam logic [ADDR_W-1:0] OFS_A_LO_S = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_A_HI_S = 8'h06;
  localparam logic [ADDR_W-1:0] OFS_B_LO   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_B_HI   = 8'h12;
  localparam logic [ADDR_W-1:0] OFS_RES0   = 8'h14;

  typedef enum logic { MODE_UNS = 1'b0, MODE_SGN = 1'b1 } mul_mode_e;

  typedef struct packed {
    logic a_lo_u;
    logic a_lo_s;
    logic a_hi;
    logic b_lo;
    logic b_hi;
  } wr_dec_t;
endpackage

// File: rtl/mul32_wdec.sv
module mul32_wdec
  import mul32_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output wr_dec_t           dec
);
  always_comb begin
    dec        = '0;
    dec.a_lo_u = wr && (addr == OFS_A_LO_U);
    dec.a_lo_s = wr && (addr == OFS_A_LO_S);
    dec.a_hi   = wr && ((addr == OFS_A_HI_U) || (addr == OFS_A_HI_S));
    dec.b_lo   = wr && (addr == OFS_B_LO);
    dec.b_hi   = wr && (addr == OFS_B_HI);
  end
endmodule

// File: rtl/mul32_core.sv
module mul32_core
  import mul32_pkg::*;
(
  input  logic [OPW-1:0]   op_a,
  input  logic [OPW-1:0]   op_b,
  input  mul_mode_e        mode,
  output logic [PRODW-1:0] prod
);
  logic [PRODW-1:0] ext_a;
  logic [PRODW-1:0] ext_b;
  logic             fill_a;
  logic             fill_b;

  always_comb begin
    fill_a = (mode == MODE_SGN) && op_a[OPW-1];
    fill_b = (mode == MODE_SGN) && op_b[OPW-1];
    ext_a  = {{OPW{fill_a}}, op_a};
    ext_b  = {{OPW{fill_b}}, op_b};
    prod   = ext_a * ext_b;
  end
endmodule

// File: rtl/mul32_rdmux.sv
module mul32_rdmux
  import mul32_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic [PRODW-1:0]  prod,
  output logic [BUS_W-1:0]  rdata
);
  logic [NWORDS-1:0][BUS_W-1:0] sel;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] WOFS = OFS_RES0 + ADDR_W'(2 * w);
    assign sel[w] = (rd && addr == WOFS) ? prod[w*BUS_W +: BUS_W] : '0;
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWORDS; w++) rdata = rdata | sel[w];
  end
endmodule

// File: rtl/mul32_periph.sv
module mul32_periph
  import mul32_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata
);
  wr_dec_t          dec;
  logic [OPW-1:0]   op_a_q, op_a_d;
  logic [OPW-1:0]   op_b_q, op_b_d;
  mul_mode_e        mode_q, mode_d;
  logic [PRODW-1:0] prod_q, prod_comb;
  logic [OPW-1:0]   b_full;
  logic             en_a, en_b, en_p;

  mul32_wdec u_wdec (.addr(bus_addr), .wr(bus_wr), .dec(dec));

  always_comb begin
    op_a_d = op_a_q;
    mode_d = mode_q;
    op_b_d = op_b_q;
    en_a   = dec.a_lo_u | dec.a_lo_s | dec.a_hi;
    en_b   = dec.b_lo | dec.b_hi;
    en_p   = dec.b_hi;
    if (dec.a_lo_u) begin
      op_a_d = {{BUS_W{1'b0}}, bus_wdata};
      mode_d = MODE_UNS;
    end else if (dec.a_lo_s) begin
      op_a_d = {{BUS_W{1'b0}}, bus_wdata};
      mode_d = MODE_SGN;
    end else if (dec.a_hi) begin
      op_a_d = {bus_wdata, op_a_q[BUS_W-1:0]};
    end
    if (dec.b_lo)      op_b_d = {op_b_q[OPW-1:BUS_W], bus_wdata};
    else if (dec.b_hi) op_b_d = {bus_wdata, op_b_q[BUS_W-1:0]};
    b_full = {bus_wdata, op_b_q[BUS_W-1:0]};
  end

  mul32_core u_core (.op_a(op_a_q), .op_b(b_full), .mode(mode_q), .prod(prod_comb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_a_q <= '0;
      op_b_q <= '0;
      mode_q <= MODE_UNS;
      prod_q <= '0;
    end else begin
      if (en_a) begin
        op_a_q <= op_a_d;
        mode_q <= mode_d;
      end
      if (en_b) op_b_q <= op_b_d;
      if (en_p) prod_q <= prod_comb;
    end
  end

  mul32_rdmux u_rd (.addr(bus_addr), .rd(bus_rd), .prod(prod_q), .rdata(bus_rdata));
endmodule

// File: rtl/mul32_checker.sv
module mul32_checker
  import mul32_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [OPW-1:0]    op_a_q,
  input logic [OPW-1:0]    op_b_q,
  input logic [PRODW-1:0]  prod_q
);
  logic trig;
  logic mapped_rd;
  assign trig      = bus_wr && bus_addr == OFS_B_HI;
  assign mapped_rd = bus_addr == 8'h14 || bus_addr == 8'h16 ||
                     bus_addr == 8'h18 || bus_addr == 8'h1A;

  // R6: product changes only after a trigger write
  a_r6_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(prod_q));

  // R2 / R3: loader writes clear operand A upper half
  a_r2_r3_a_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_A_LO_U || bus_addr == OFS_A_LO_S))
    |=> op_a_q[OPW-1:BUS_W] == '0);

  // R6: operand B low half survives the trigger write
  a_r6_b_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> op_b_q[BUS_W-1:0] == $past(op_b_q[BUS_W-1:0]));

  // R10: unmapped or idle reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !mapped_rd) |-> bus_rdata == '0);

  // R5: operand B low write keeps upper half
  a_r5_b_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_B_LO) |=> op_b_q[OPW-1:BUS_W] == $past(op_b_q[OPW-1:BUS_W]));
endmodule

bind mul32_periph mul32_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .op_a_q(op_a_q), .op_b_q(op_b_q), .prod_q(prod_q)
);

// File: tb/tb_mul32_periph.sv
module tb_mul32_periph;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic        bus_rd;
  logic [15:0] bus_rdata;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mul32_periph dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata));

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_prod(output logic [63:0] p);
    logic [15:0] w0, w1, w2, w3;
    rd(8'h14, w0); rd(8'h16, w1); rd(8'h18, w2); rd(8'h1A, w3);
    p = {w3, w2, w1, w0};
  endtask

  task automatic run_mul(input bit sgn, input logic [31:0] a, input logic [31:0] b, input string req);
    logic [63:0] p, e;
    wr(sgn ? 8'h04 : 8'h00, a[15:0]);
    wr(sgn ? 8'h06 : 8'h02, a[31:16]);
    wr(8'h10, b[15:0]);
    wr(8'h12, b[31:16]);
    if (sgn) e = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
    else     e = {32'h0, a} * {32'h0, b};
    rd_prod(p);
    chk(req, p, e);
  endtask

  task automatic t_reset;
    logic [63:0] p;
    rd_prod(p);
    chk("R1 reset product", p, 64'h0);
    wr(8'h12, 16'h0000);
    rd_prod(p);
    chk("R1 reset operands zero", p, 64'h0);
  endtask

  task automatic t_timing;
    logic [15:0] d;
    wr(8'h00, 16'h0003);
    wr(8'h10, 16'h0005);
    @(negedge clk);
    bus_addr = 8'h12; bus_wr = 1'b1; bus_wdata = 16'h0000;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h14; bus_rd = 1'b1;
    #1 d = bus_rdata; bus_rd = 1'b0;
    chk("R6 product on cycle after trigger", 64'(d), 64'hF);
  endtask

  task automatic t_clear_hi;
    logic [63:0] p;
    wr(8'h02, 16'hFFFF);
    wr(8'h00, 16'h0002);
    wr(8'h10, 16'h0003);
    wr(8'h12, 16'h0000);
    rd_prod(p);
    chk("R2 unsigned low write clears A high", p, 64'h6);
    wr(8'h02, 16'hFFFF);
    wr(8'h04, 16'h0002);
    wr(8'h12, 16'h0000);
    rd_prod(p);
    chk("R3 signed low write clears A high", p, 64'h6);
  endtask

  task automatic t_hi_keep;
    logic [63:0] p;
    wr(8'h04, 16'h0001);
    wr(8'h02, 16'h8000);
    wr(8'h10, 16'h0001);
    wr(8'h12, 16'h0000);
    rd_prod(p);
    chk("R4 A high keeps low and signed mode", p, 64'hFFFFFFFF80000001);
  endtask

  task automatic t_b_lo;
    logic [63:0] p;
    wr(8'h00, 16'h0001);
    wr(8'h10, 16'h0001);
    wr(8'h12, 16'h0002);
    wr(8'h10, 16'h0007);
    rd_prod(p);
    chk("R5 B low write leaves product", p, 64'h20001);
    wr(8'h12, 16'h0002);
    rd_prod(p);
    chk("R5 B low write kept with old high", p, 64'h20007);
  endtask

  task automatic t_unmapped;
    logic [63:0] p, p2;
    logic [15:0] d;
    run_mul(1'b0, 32'h12345678, 32'h9ABCDEF0, "R7 unsigned mixed");
    rd_prod(p);
    wr(8'h08, 16'hFFFF);
    wr(8'h14, 16'hFFFF);
    wr(8'h13, 16'hFFFF);
    rd_prod(p2);
    chk("R10 unmapped writes leave product", p2, p);
    rd(8'h20, d);
    chk("R10 unmapped read zero", 64'(d), 64'h0);
    rd(8'h10, d);
    chk("R10 operand offset read zero", 64'(d), 64'h0);
    wr(8'h12, 16'h9ABC);
    rd_prod(p2);
    chk("R10 operands and mode untouched", p2, p);
  endtask

  initial begin
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timing();
    t_clear_hi();
    t_hi_keep();
    t_b_lo();
    run_mul(1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, "R7 unsigned max");
    run_mul(1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, "R8 signed -1*-1");
    run_mul(1'b1, 32'h80000000, 32'h80000000, "R8 signed min*min");
    run_mul(1'b1, 32'h80000000, 32'h00000003, "R8 signed neg*pos");
    run_mul(1'b1, 32'h7FFFFFFF, 32'hFFFFFFFE, "R8 signed max*-2");
    run_mul(1'b0, 32'h00010002, 32'h00030004, "R9 word lanes");
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule